// File: doc/BRIEF.md
# Biphase-mark stereo audio line transmitter

This block sends a stereo audio stream on one serial line in the consumer digital audio interface format. Each subframe is 32 time slots long. Slots 0 to 3 hold a synchronising preamble. Slots 4 to 27 hold a 24-bit sample, least significant bit first. The last four slots carry the validity flag, the user-data flag, the channel-status flag and a parity bit that the block computes itself. Two subframes make a frame: channel A is sent first, then channel B. A block counter spans a configurable number of frames and decides which preamble goes out.

Samples arrive through a ready/valid interface with a one-entry holding register. The words are consumed strictly in order, one per subframe, so the producer supplies A and B samples alternately. The line advances one half-bit on each pulse of `hb_tick`, which the surrounding design generates at twice the bit rate. For 48 kHz audio that is 6.144 MHz, because a frame is 64 bit times. If no word is held when a subframe begins, the block sends a silent subframe and marks it invalid.

Top module: `spdif_tx`

## Requirements
- R1: While `rst` is high, `sdo` equals `RESET_LEVEL` and `s_ready` is 1. The first subframe after reset is channel A of frame 0.
- R2: `sdo` changes only in the clock cycle after a cycle with `hb_tick` high. Each tick produces exactly one half-bit, and a subframe is 64 half-bits.
- R3: The first 8 half-bits of a subframe form the preamble. If the line level before the subframe is 0, the patterns (first half-bit on the left) are 11101000 for the block-start preamble, 11100010 for the channel-A preamble and 11100100 for the channel-B preamble. If that level is 1, every bit is inverted.
- R4: Channel A of frame 0 carries the block-start preamble, channel A of every other frame carries the channel-A preamble, and channel B always carries the channel-B preamble. The frame index wraps to 0 after `BLOCK_FRAMES` frames.
- R5: Slots 4 to 27 carry the sample, with bit 0 in slot 4. Every slot from 4 on begins with a line transition and has a second transition mid-slot exactly when its bit is 1.
- R6: Slots 28, 29 and 30 carry the `s_vbit`, `s_ubit` and `s_cbit` values that were accepted with the sample.
- R7: Slot 31 makes the count of ones in slots 4 to 31 even. As a result, the line level at every subframe boundary equals `RESET_LEVEL`.
- R8: A word is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low while a word is held. A held word is sent in the next subframe that starts on a later edge, and words go out in acceptance order.
- R9: If no word is held when a subframe starts, that subframe carries zero sample data, user and channel-status bits of 0, and a validity bit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | One-cycle pulse per half-bit period |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Holding register empty; a word can be taken |
| s_data | input | 24 | Audio sample |
| s_vbit | input | 1 | Validity flag for the sample |
| s_ubit | input | 1 | User-data bit for the sample |
| s_cbit | input | 1 | Channel-status bit for the sample |
| sdo | output | 1 | Biphase-mark encoded serial line |

## Verification
The bench builds the block with `BLOCK_FRAMES` = 4, so the frame index wraps three times in a short run and the block-start preamble is seen again after each wrap. It also sets `RESET_LEVEL` = 1, so every subframe starts from a high line and the inverted preamble patterns are exercised. The tick spacing is irregular and includes a phase with back-to-back ticks. A stretch with no samples offered forces invalid silent subframes.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int SAMPLE_W     = 24;
  localparam int SLOTS_PER_SF = 32;
  localparam int HALVES_PER_SF = 2 * SLOTS_PER_SF;
  localparam int HB_W         = $clog2(HALVES_PER_SF);
  localparam int PRE_HALVES   = 8;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // Half-bit pattern for a line that was low before the subframe.
  function automatic logic [PRE_HALVES-1:0] pre_pattern(pre_kind_e k);
    case (k)
      PRE_BLOCK: return 8'b1110_1000;
      PRE_LEFT:  return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/spdif_tx_timing.sv
module spdif_tx_timing
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hb_tick,
  output logic [HB_W-1:0] hb_idx,
  output logic            sf_start,
  output pre_kind_e       pre_kind
);

  localparam int FW = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;
  localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_FRAMES - 1);
  localparam logic [HB_W-1:0] LAST_HALF = HB_W'(HALVES_PER_SF - 1);

  logic          chan_b;
  logic [FW-1:0] frame_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_idx    <= '0;
      chan_b    <= 1'b0;
      frame_idx <= '0;
    end else if (hb_tick) begin
      hb_idx <= (hb_idx == LAST_HALF) ? '0 : hb_idx + 1'b1;
      if (hb_idx == LAST_HALF) begin
        chan_b <= ~chan_b;
        if (chan_b)
          frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + 1'b1;
      end
    end
  end

  assign sf_start = hb_tick && (hb_idx == '0);

  always_comb begin
    if (chan_b)                pre_kind = PRE_RIGHT;
    else if (frame_idx == '0)  pre_kind = PRE_BLOCK;
    else                       pre_kind = PRE_LEFT;
  end

endmodule

// File: rtl/spdif_tx_hold.sv
module spdif_tx_hold
  import spdif_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_v,
  input  logic                in_u,
  input  logic                in_c,
  input  logic                take,
  output logic                full,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_v,
  output logic                out_u,
  output logic                out_c
);

  logic accept;
  assign accept   = in_valid && !full;
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else begin
      if (take)   full <= 1'b0;
      if (accept) full <= 1'b1;
    end
  end

  // Payload needs no reset: it is only read while full is set.
  always_ff @(posedge clk) begin
    if (accept) begin
      out_data <= in_data;
      out_v    <= in_v;
      out_u    <= in_u;
      out_c    <= in_c;
    end
  end

endmodule

// File: rtl/spdif_tx_encoder.sv
module spdif_tx_encoder
  import spdif_tx_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hb_tick,
  input  logic [HB_W-1:0]     hb_idx,
  input  logic                sf_start,
  input  pre_kind_e           pre_kind,
  input  logic                have_word,
  input  logic [SAMPLE_W-1:0] w_data,
  input  logic                w_v,
  input  logic                w_u,
  input  logic                w_c,
  output logic                line
);

  logic [SLOTS_PER_SF-1:4]   slots_q;
  logic [PRE_HALVES-2:0]     pre_q;
  logic [PRE_HALVES-1:0]     pre_now;
  logic [SAMPLE_W-1:0]       d_sel;
  logic                      v_sel, u_sel, c_sel, par;
  logic [SLOTS_PER_SF-1:4]   word_now;
  logic                      nh;

  assign d_sel = have_word ? w_data : '0;
  assign v_sel = have_word ? w_v : 1'b1;
  assign u_sel = have_word & w_u;
  assign c_sel = have_word & w_c;
  assign par   = ^{d_sel, v_sel, u_sel, c_sel};
  assign word_now = {par, c_sel, u_sel, v_sel, d_sel};

  assign pre_now = pre_pattern(pre_kind) ^ {PRE_HALVES{line}};

  always_comb begin
    if (hb_idx == '0)
      nh = pre_now[PRE_HALVES-1];
    else if (hb_idx < HB_W'(PRE_HALVES))
      nh = pre_q[3'd7 - hb_idx[2:0]];
    else if (!hb_idx[0])
      nh = ~line;
    else
      nh = slots_q[hb_idx[HB_W-1:1]] ? ~line : line;
  end

  always_ff @(posedge clk) begin
    if (rst) line <= RESET_LEVEL;
    else if (hb_tick) line <= nh;
  end

  always_ff @(posedge clk) begin
    if (sf_start) begin
      pre_q   <= pre_now[PRE_HALVES-2:0];
      slots_q <= word_now;
    end
  end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int   BLOCK_FRAMES = 192,
  parameter logic RESET_LEVEL  = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hb_tick,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [23:0] s_data,
  input  logic        s_vbit,
  input  logic        s_ubit,
  input  logic        s_cbit,
  output logic        sdo
);

  logic [HB_W-1:0]     hb_idx;
  logic                sf_start;
  pre_kind_e           pre_kind;
  logic                held;
  logic [SAMPLE_W-1:0] h_data;
  logic                h_v, h_u, h_c;
  logic                take;

  assign take = sf_start && held;

  spdif_tx_timing #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_timing (
    .clk      (clk),
    .rst      (rst),
    .hb_tick  (hb_tick),
    .hb_idx   (hb_idx),
    .sf_start (sf_start),
    .pre_kind (pre_kind)
  );

  spdif_tx_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_data  (s_data),
    .in_v     (s_vbit),
    .in_u     (s_ubit),
    .in_c     (s_cbit),
    .take     (take),
    .full     (held),
    .out_data (h_data),
    .out_v    (h_v),
    .out_u    (h_u),
    .out_c    (h_c)
  );

  spdif_tx_encoder #(.RESET_LEVEL(RESET_LEVEL)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .hb_tick   (hb_tick),
    .hb_idx    (hb_idx),
    .sf_start  (sf_start),
    .pre_kind  (pre_kind),
    .have_word (held),
    .w_data    (h_data),
    .w_v       (h_v),
    .w_u       (h_u),
    .w_c       (h_c),
    .line      (sdo)
  );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter logic RESET_LEVEL = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       hb_tick,
  input logic       sdo,
  input logic       s_valid,
  input logic       s_ready,
  input logic [5:0] hb_idx,
  input logic       sf_start
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hb_tick |=> $stable(sdo)); // R2

  AST_PRE_OPENS: assert property (@(posedge clk) disable iff (rst)
    sf_start |=> sdo != $past(sdo)); // R3

  AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (hb_tick && hb_idx >= 6'd8 && !hb_idx[0]) |=> sdo != $past(sdo)); // R5

  AST_BOUNDARY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> sdo == RESET_LEVEL); // R7

  AST_HOLD_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready); // R8

endmodule

bind spdif_tx spdif_tx_chk #(.RESET_LEVEL(RESET_LEVEL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hb_tick  (hb_tick),
  .sdo      (sdo),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .hb_idx   (hb_idx),
  .sf_start (sf_start)
);

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;

  localparam int BF = 4;
  localparam bit RL = 1'b1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb_tick = 1'b0;
  logic        s_valid = 1'b0;
  logic [23:0] s_data = '0;
  logic        s_vbit = 1'b0, s_ubit = 1'b0, s_cbit = 1'b0;
  wire         s_ready, sdo;

  always #4 clk = ~clk;

  spdif_tx #(.BLOCK_FRAMES(BF), .RESET_LEVEL(RL)) u_spdif_tx (
    .clk(clk), .rst(rst), .hb_tick(hb_tick), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_vbit(s_vbit),
    .s_ubit(s_ubit), .s_cbit(s_cbit), .sdo(sdo)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Behavioural reference state
  int     m_hb = 0, m_sub = 0, m_frame = 0, m_sf_done = 0, m_kind = 0;
  bit     m_line = RL, m_prev = RL, m_full = 0, m_took = 0, m_fill = 0, m_tk = 0;
  bit     m_bits[32];
  bit [7:0]  m_pre;
  bit [23:0] m_qd;
  bit        m_qv, m_qu, m_qc;
  string     m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_hb = 0; m_sub = 0; m_frame = 0; m_line = RL;
      m_full = 0; m_took = 0; m_tag = "R1";
    end else begin
      m_tk = s_valid && !m_full;
      if (!hb_tick) m_tag = "R2";
      else begin
        if (m_hb == 0) begin
          int ones;
          bit [23:0] d; bit v, u, c;
          m_fill = !m_full;
          if (m_full) begin d = m_qd; v = m_qv; u = m_qu; c = m_qc; m_full = 0; end
          else begin d = '0; v = 1; u = 0; c = 0; end
          for (int i = 0; i < 24; i++) m_bits[4+i] = d[i];
          m_bits[28] = v; m_bits[29] = u; m_bits[30] = c;
          ones = 0;
          for (int i = 4; i < 31; i++) ones += m_bits[i];
          m_bits[31] = ones % 2;
          m_kind = (m_sub == 1) ? 2 : ((m_frame == 0) ? 0 : 1);
          m_pre  = (m_kind == 0) ? 8'b11101000 : ((m_kind == 1) ? 8'b11100010 : 8'b11100100);
          m_prev = m_line;
        end
        if (m_hb < 8) begin
          m_line = m_pre[7-m_hb] ^ m_prev;
          m_tag  = (m_kind == 0) ? "R4" : "R3";
        end else begin
          if (m_hb % 2 == 0) m_line = !m_line;
          else if (m_bits[m_hb/2]) m_line = !m_line;
          if (m_hb / 2 == 31)      m_tag = "R7";
          else if (m_fill)         m_tag = "R9";
          else if (m_hb / 2 >= 28) m_tag = "R6";
          else                     m_tag = "R5";
        end
        m_hb++;
        if (m_hb == 64) begin
          m_hb = 0;
          if (m_sub == 1) m_frame = (m_frame + 1) % BF;
          m_sub ^= 1;
          m_sf_done++;
        end
      end
      if (m_tk) begin
        m_full = 1; m_qd = s_data; m_qv = s_vbit; m_qu = s_ubit; m_qc = s_cbit;
      end
      m_took = m_tk;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (sdo !== m_line) begin
        n_bad++;
        $display("FAIL %s sdo actual %0b expected %0b (t=%0t)", m_tag, sdo, m_line, $time);
      end
      n_cmp++;
      if (s_ready !== !m_full) begin
        n_bad++;
        $display("FAIL %s s_ready actual %0b expected %0b (t=%0t)",
                 rst ? "R1" : "R8", s_ready, !m_full, $time);
      end
    end
  end

  // Stimulus: tick pattern and producer
  int  gcnt = 0, nsamp = 0;
  bit  fast = 0, offer = 0;
  bit [31:0] lfsr = 32'h1234_5678;

  always @(negedge clk) begin
    gcnt++;
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    if (rst) hb_tick = 0;
    else if (fast) hb_tick = 1;
    else hb_tick = ((gcnt % 7) == 0) || ((gcnt % 7) == 2) || ((gcnt % 7) == 3) || ((gcnt % 7) == 5);
    if (!rst) begin
      if (m_took) s_valid = 0;
      if (!s_valid && offer && lfsr[3]) begin
        s_valid = 1;
        case (nsamp % 4)
          0: s_data = 24'hFFFFFF;
          1: s_data = 24'h000000;
          default: s_data = lfsr[27:4];
        endcase
        s_vbit = lfsr[0]; s_ubit = lfsr[1]; s_cbit = lfsr[2];
        nsamp++;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0; offer = 1;
    while (m_sf_done < 10) @(negedge clk);
    offer = 0;                               // R9 underrun stretch
    while (m_sf_done < 15) @(negedge clk);
    offer = 1; fast = 1;
    while (m_sf_done < 26) @(negedge clk);  // R4 wrap seen three times
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule